// File: doc/BRIEF.md
# Serial Gamepad Read Port

This block lets a CPU read two eight-button game controllers through a small register window, one button at a time. A write to the strobe address freezes the current button state of both controllers into snapshot registers and rewinds both read positions. After that, every read of a controller's data address returns one button of that controller's snapshot and moves that controller's position forward. The two controllers have separate positions, so software can read them interleaved or one after the other.

Each read returns the button in data bit 0 and zeros in the upper bits. After all eight buttons have been read, the position stops at the end and every further read returns 1. Read data is combinational, so it is valid in the same cycle as the read strobe. The position moves on the clock edge that ends the read cycle. The strobe address is also the data address of controller 0.

Top module: `gamepad_serial_port`

## Requirements
- R1: A write (`wr_en`) to the strobe address (default 0x4016) copies both live button vectors into the snapshots and sets both read positions to 0.
- R2: A read (`rd_en`) of the strobe address returns the next button of controller 0. A read of the second data address (default 0x4017) returns the next button of controller 1.
- R3: The read at position n (0 to 7) returns bit n of the snapshot. The live vector bits are assigned as follows: bit 0 = A, 1 = B, 2 = Select, 3 = Start, 4 = Up, 5 = Down, 6 = Left, 7 = Right. A pressed button (input 1) reads as 1 and a released button reads as 0.
- R4: Each read moves only the position of the controller that was read.
- R5: Once a position reaches 8 it stays at 8, and every later read of that controller returns 1 until the next strobe write.
- R6: `rd_data` carries the button in bit 0, and bits 7:1 are 0. `rd_data` is all zero in any cycle without a read of either data address.
- R7: Changes to the live button inputs after a strobe write have no effect on reads until the next strobe write.
- R8: When a strobe write and a read happen in the same cycle, the read returns the button at the old position, and both positions are 0 afterwards.
- R9: After reset both snapshots are zero and both positions are 0. Eight reads of either controller then return 0, and every later read returns 1.
- R10: Writes to any address other than the strobe address have no effect on the snapshots or positions. Reads of any other address leave both positions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| pad0_buttons | input | 8 | Live buttons of controller 0, 1 = pressed |
| pad1_buttons | input | 8 | Live buttons of controller 1, 1 = pressed |
| rd_data | output | 8 | Read data, button in bit 0 |

## Verification
The assertions assume the following about the inputs:
- Each read or write strobe lasts exactly one clock cycle per access.
- The address is stable while a strobe is high.
- The live button inputs are known values, never X.

The bench drives every access as a single-cycle pulse between falling edges and always drives the button vectors with defined patterns. It samples `rd_data` late in the cycle of the read, before the edge that advances the position.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
  localparam int PORTS = 2;

  typedef struct packed {
    logic       load;
    logic [1:0] adv;
  } gpad_ctl_t;
endpackage

// File: rtl/gpad_decode.sv
module gpad_decode
  import gpad_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT1_ADDR  = 16'h4017
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output gpad_ctl_t         ctl
);
  logic hit_strobe, hit_port1;

  assign hit_strobe = (addr == STROBE_ADDR);
  assign hit_port1  = (addr == PORT1_ADDR);

  assign ctl.load   = wr_en & hit_strobe;
  assign ctl.adv[0] = rd_en & hit_strobe;
  assign ctl.adv[1] = rd_en & hit_port1;

  // R4: a single read never advances both controllers
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl.adv));
  // R10: a write elsewhere never loads the snapshots
  a_r10_no_stray_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != STROBE_ADDR) |-> !ctl.load);
endmodule

// File: rtl/gpad_lane.sv
module gpad_lane #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] live,
  input  logic          load,
  input  logic          adv,
  output logic          bit_out
);
  logic [NB-1:0] snap;
  logic [IW-1:0] idx;

  function automatic logic pick(input logic [NB-1:0] s, input logic [IW-1:0] i);
    logic [NB-1:0] sh;
    if (i >= IW'(NB)) return 1'b1;
    sh = s >> i;
    return sh[0];
  endfunction

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i >= IW'(NB)) ? i : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= '0;
      idx  <= '0;
    end else if (load) begin
      snap <= live;
      idx  <= '0;
    end else if (adv) begin
      idx  <= next_idx(idx);
    end
  end

  assign bit_out = pick(snap, idx);

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == '0) && (snap == $past(live)));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && idx < IW'(NB)) |=> idx == $past(idx) + 1'b1);
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NB));
  a_r5_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IW'(NB)) |-> bit_out);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(idx));
endmodule

// File: rtl/gamepad_serial_port.sv
module gamepad_serial_port
  import gpad_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              NB          = 8,
  parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT1_ADDR  = 16'h4017
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NB-1:0]     pad0_buttons,
  input  logic [NB-1:0]     pad1_buttons,
  output logic [DATA_W-1:0] rd_data
);
  gpad_ctl_t     ctl;
  logic [NB-1:0] live [PORTS];
  logic [PORTS-1:0] lane_bit;

  assign live[0] = pad0_buttons;
  assign live[1] = pad1_buttons;

  gpad_decode #(
    .ADDR_W(ADDR_W), .STROBE_ADDR(STROBE_ADDR), .PORT1_ADDR(PORT1_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .ctl(ctl)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_lane
    gpad_lane #(.NB(NB)) u_lane (
      .clk(clk), .rst_n(rst_n), .live(live[p]),
      .load(ctl.load), .adv(ctl.adv[p]), .bit_out(lane_bit[p])
    );
  end

  always_comb begin
    rd_data = '0;
    if (ctl.adv[0])      rd_data[0] = lane_bit[0];
    else if (ctl.adv[1]) rd_data[0] = lane_bit[1];
  end

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:1] == '0);
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.adv == '0) |-> rd_data == '0);
endmodule

// File: tb/tb_gamepad_serial_port.sv
`timescale 1ns/1ps
module tb_gamepad_serial_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = 16'h0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  pad0 = 8'h0, pad1 = 8'h0;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0;
  logic [7:0] m_snap [2];
  int         m_idx  [2];

  always #4 clk = ~clk;

  gamepad_serial_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .pad0_buttons(pad0), .pad1_buttons(pad1), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_bit(input int p);
    if (m_idx[p] >= 8) return 8'h01;
    return {7'b0, m_snap[p][m_idx[p]]};
  endfunction

  task automatic strobe(input logic [15:0] a);
    @(negedge clk);
    addr = a; wr_en = 1;
    #2 check("R6 idle on write", rd_data, 8'h00);
    @(negedge clk);
    wr_en = 0;
    if (a == 16'h4016) begin
      m_snap[0] = pad0; m_snap[1] = pad1; m_idx[0] = 0; m_idx[1] = 0;
    end
  endtask

  task automatic rd(input int p, input string req);
    @(negedge clk);
    addr = (p == 0) ? 16'h4016 : 16'h4017; rd_en = 1;
    #2 check(req, rd_data, exp_bit(p));
    @(negedge clk);
    rd_en = 0;
    if (m_idx[p] < 8) m_idx[p]++;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_snap[0] = 0; m_snap[1] = 0; m_idx[0] = 0; m_idx[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R9 reset idle data", rd_data, 8'h00);
    // R9: reset state, zeros then ones
    for (int k = 0; k < 10; k++) rd(0, "R9 port0 after reset");
    for (int k = 0; k < 10; k++) rd(1, "R9 port1 after reset");

    // R1 R2 R3 R5: sweep patterns, interleaved reads
    for (int t = 0; t < 20; t++) begin
      pad0 = (t < 8) ? (8'h01 << t) : 8'(t * 37 + 5);
      pad1 = (t < 8) ? ~(8'h01 << t) : 8'(t * 91 + 3);
      strobe(16'h4016);
      for (int k = 0; k < 11; k++) begin
        rd(0, "R3 port0 order");
        rd(1, "R2 port1 select");
      end
    end

    // R4: independent positions
    pad0 = 8'hA5; pad1 = 8'h3C;
    strobe(16'h4016);
    for (int k = 0; k < 5; k++) rd(0, "R4 port0 alone");
    for (int k = 0; k < 9; k++) rd(1, "R4 port1 fresh");
    for (int k = 0; k < 5; k++) rd(0, "R5 port0 continues");

    // R7: live changes after strobe ignored
    pad0 = 8'h0F; pad1 = 8'hF0;
    strobe(16'h4016);
    pad0 = 8'hF0; pad1 = 8'h0F;
    for (int k = 0; k < 9; k++) begin rd(0, "R7 port0 frozen"); rd(1, "R7 port1 frozen"); end

    // R10: stray write and stray read
    pad0 = 8'h55; pad1 = 8'hAA;
    strobe(16'h4016);
    rd(0, "R10 setup"); rd(1, "R10 setup");
    pad0 = 8'hFF; pad1 = 8'hFF;
    strobe(16'h4017);
    @(negedge clk); addr = 16'h4015; rd_en = 1;
    #2 check("R10 stray read data", rd_data, 8'h00);
    @(negedge clk); rd_en = 0;
    for (int k = 0; k < 8; k++) begin rd(0, "R10 unchanged port0"); rd(1, "R10 unchanged port1"); end

    // R8: simultaneous strobe write and read
    pad0 = 8'h81; pad1 = 8'h42;
    strobe(16'h4016);
    rd(0, "R8 setup"); rd(0, "R8 setup"); rd(1, "R8 setup");
    pad0 = 8'h7E; pad1 = 8'hBD;
    @(negedge clk); addr = 16'h4016; wr_en = 1; rd_en = 1;
    #2 check("R8 old position bit", rd_data, exp_bit(0));
    @(negedge clk); wr_en = 0; rd_en = 0;
    m_snap[0] = pad0; m_snap[1] = pad1; m_idx[0] = 0; m_idx[1] = 0;
    for (int k = 0; k < 9; k++) begin rd(0, "R8 restart port0"); rd(1, "R8 restart port1"); end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule